// File: doc/BRIEF.md
# Codec Mixer Register File

This block holds the control registers of an audio codec mixer. Software reaches them through a simple single-beat register bus. The register space is 256 bytes and holds 16-bit registers at even addresses. Every write passes through the rules of its target register:
- Volume and record-select writes are masked to their defined fields.
- Identification and unimplemented registers refuse writes.
- Power-down status bits survive writes.
- Sample-rate registers only move when their variable-rate enable is set in the extended control register.

A write of any value to the reset register, or the synchronous reset pin, brings every register back to its power-up value. The decoded volume, mute, record-source and sample-rate fields are driven out as registered signals for the audio datapath.

Registers without special rules live in an inferable RAM. A per-entry "written since reset" flag marks each entry, so a reset needs only a single cycle.

Top module: `codec_mixer_regs`

## Requirements
- R1: After `rst` the registers read: master volume 0x8000, PCM out volume 0x8808, record gain 0x8808, record select 0x0000, power-down 0x000F, extended ID 0x0809, extended control 0x0009, vendor IDs 0x8384 (0x7C) and 0x7600 (0x7E), and all five rate registers 0xBB80. The decoded outputs match these values.
- R2: Writes are ANDed with a mask before they are stored: master (0x02) with 0xBF3F, PCM out (0x18) with 0x9F1F, record gain (0x1C) with 0x8F0F. Bit 15 is the mute bit. Left and right levels sit at bits 13:8/5:0 (master), 12:8/4:0 (PCM) and 11:8/3:0 (gain).
- R3: Record select (0x1A) keeps a 3-bit source per side: right at bits 2:0 and left at bits 10:8. All other bits read 0.
- R4: A power-down (0x26) write stores bits 14:4 from the bus. Bit 15 is stored as 0, and bits 3:0 keep their previous value.
- R5: Writes to 0x28, 0x7C, 0x7E and to 0x04–0x16 (even), 0x1E, 0x20 and 0x22 are ignored. The latter group always reads 0.
- R6: The front DAC rate (0x2C) and the ADC rate (0x32) accept writes only while extended control bit 0 is set. The mic rate (0x34) accepts writes only while bit 3 is set.
- R7: A write to extended control (0x2A) stores the written value. If bit 0 of that value is 0, the DAC and ADC rates are forced to 0xBB80. If bit 3 is 0, the mic rate is forced to 0xBB80.
- R8: Every other even address is plain 16-bit read/write storage. After a reset it reads 0x0000, except 0x2E and 0x30, which read 0xBB80.
- R9: The `req_size` encoding is 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = reserved. Only size 1 is served. Any other read returns 0xFFFFFFFF, and any other write changes nothing.
- R10: A 16-bit access to an odd address reads 0xFFFFFFFF, and a 16-bit write to an odd address changes nothing.
- R11: A 16-bit write of any value to 0x00 restores every R1 value and every R8 default. Address 0x00 reads 0x0000.
- R12: `rsp_valid` is high exactly in the cycle after a read request and never after a write. A served read returns the register in bits 15:0 with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size (see R9) |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| master_mute | output | 1 | Master mute |
| master_vol_l | output | 6 | Master left attenuation |
| master_vol_r | output | 6 | Master right attenuation |
| pcm_mute | output | 1 | PCM out mute |
| pcm_vol_l | output | 5 | PCM left attenuation |
| pcm_vol_r | output | 5 | PCM right attenuation |
| rec_mute | output | 1 | Record gain mute |
| rec_gain_l | output | 4 | Record left gain |
| rec_gain_r | output | 4 | Record right gain |
| rec_src_l | output | 3 | Left record source |
| rec_src_r | output | 3 | Right record source |
| front_dac_rate | output | 16 | Front DAC sample rate |
| adc_rate | output | 16 | Left/right ADC sample rate |
| mic_rate | output | 16 | Mic ADC sample rate |

## Verification
The bench writes a rate while its enable is clear and expects the value not to move. A design that ignores the gate would show the new rate on the port. The bench also clears one variable-rate enable while leaving the other set and expects only the matching rates to fall back to 0xBB80. A design that forces rates regardless of the enable, or couples the audio and mic enables, would show the wrong rates.

It writes all ones to the power-down and masked registers. A missing preserve or mask shows up as bit 15 set or as stray bits set. It fills plain storage and 0x2E, then writes the reset register and expects 0 and 0xBB80 to come back. Byte, 32-bit and odd-address accesses are also driven and must leave the target register as it was.

// File: rtl/mixreg_pkg.sv
package mixreg_pkg;
  localparam int REG_W = 16;

  localparam logic [15:0] RATE_48K    = 16'hBB80;
  localparam logic [15:0] MASK_MASTER = 16'hBF3F;
  localparam logic [15:0] MASK_PCM    = 16'h9F1F;
  localparam logic [15:0] MASK_RGAIN  = 16'h8F0F;
  localparam logic [15:0] MASK_RSEL   = 16'h0707;
  localparam logic [15:0] PWR_KEEP    = 16'h800F;

  localparam logic [15:0] DEF_MASTER  = 16'h8000;
  localparam logic [15:0] DEF_PCM     = 16'h8808;
  localparam logic [15:0] DEF_RGAIN   = 16'h8808;
  localparam logic [15:0] DEF_PWR     = 16'h000F;
  localparam logic [15:0] DEF_EXTCTL  = 16'h0009;
  localparam logic [15:0] CONST_EXTID = 16'h0809;
  localparam logic [15:0] CONST_VID1  = 16'h8384;
  localparam logic [15:0] CONST_VID2  = 16'h7600;

  localparam int VRA_BIT = 0;
  localparam int VRM_BIT = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [3:0] {
    K_PLAIN, K_RESET, K_MASTER, K_PCM, K_RSEL, K_RGAIN, K_PWR,
    K_EXTID, K_EXTCTL, K_DAC, K_ADC, K_MIC, K_VID1, K_VID2, K_LOCKED
  } reg_kind_e;
endpackage

// File: rtl/mixreg_decode.sv
module mixreg_decode
  import mixreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [REG_W-1:0]  plain_dflt
);
  always_comb begin
    case (addr)
      ADDR_W'(8'h00): kind = K_RESET;
      ADDR_W'(8'h02): kind = K_MASTER;
      ADDR_W'(8'h18): kind = K_PCM;
      ADDR_W'(8'h1A): kind = K_RSEL;
      ADDR_W'(8'h1C): kind = K_RGAIN;
      ADDR_W'(8'h26): kind = K_PWR;
      ADDR_W'(8'h28): kind = K_EXTID;
      ADDR_W'(8'h2A): kind = K_EXTCTL;
      ADDR_W'(8'h2C): kind = K_DAC;
      ADDR_W'(8'h32): kind = K_ADC;
      ADDR_W'(8'h34): kind = K_MIC;
      ADDR_W'(8'h7C): kind = K_VID1;
      ADDR_W'(8'h7E): kind = K_VID2;
      ADDR_W'(8'h04), ADDR_W'(8'h06), ADDR_W'(8'h08), ADDR_W'(8'h0A),
      ADDR_W'(8'h0C), ADDR_W'(8'h0E), ADDR_W'(8'h10), ADDR_W'(8'h12),
      ADDR_W'(8'h14), ADDR_W'(8'h16), ADDR_W'(8'h1E), ADDR_W'(8'h20),
      ADDR_W'(8'h22): kind = K_LOCKED;
      default:        kind = K_PLAIN;
    endcase
  end

  // Surround and LFE rate slots are plain storage with a 48 kHz default.
  always_comb begin
    if (addr == ADDR_W'(8'h2E) || addr == ADDR_W'(8'h30))
      plain_dflt = RATE_48K;
    else
      plain_dflt = '0;
  end
endmodule

// File: rtl/mixreg_store.sv
module mixreg_store
  import mixreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 1,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             rwritten
);
  logic [REG_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written;

  // RAM without reset so that block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      written  <= '0;
      rwritten <= 1'b0;
    end else begin
      if (we) written[idx] <= 1'b1;
      rwritten <= written[idx];
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (written == '0)); // R11
endmodule

// File: rtl/mixreg_ctrl.sv
module mixreg_ctrl
  import mixreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_kind_e        kind,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] spec_rdata,
  output logic             master_mute,
  output logic [5:0]       master_vol_l,
  output logic [5:0]       master_vol_r,
  output logic             pcm_mute,
  output logic [4:0]       pcm_vol_l,
  output logic [4:0]       pcm_vol_r,
  output logic             rec_mute,
  output logic [3:0]       rec_gain_l,
  output logic [3:0]       rec_gain_r,
  output logic [2:0]       rec_src_l,
  output logic [2:0]       rec_src_r,
  output logic [15:0]      front_dac_rate,
  output logic [15:0]      adc_rate,
  output logic [15:0]      mic_rate
);
  logic [REG_W-1:0] master_q, pcm_q, rgain_q, rsel_q, pwr_q, ext_q;
  logic [REG_W-1:0] dac_q, adc_q, mic_q;

  always_ff @(posedge clk) begin
    if (rst || (wr_en && kind == K_RESET)) begin
      master_q <= DEF_MASTER;
      pcm_q    <= DEF_PCM;
      rgain_q  <= DEF_RGAIN;
      rsel_q   <= '0;
      pwr_q    <= DEF_PWR;
      ext_q    <= DEF_EXTCTL;
      dac_q    <= RATE_48K;
      adc_q    <= RATE_48K;
      mic_q    <= RATE_48K;
    end else if (wr_en) begin
      case (kind)
        K_MASTER: master_q <= wdata & MASK_MASTER;
        K_PCM:    pcm_q    <= wdata & MASK_PCM;
        K_RGAIN:  rgain_q  <= wdata & MASK_RGAIN;
        K_RSEL:   rsel_q   <= wdata & MASK_RSEL;
        K_PWR:    pwr_q    <= (wdata & ~PWR_KEEP) | (pwr_q & 16'h000F);
        K_EXTCTL: begin
          ext_q <= wdata;
          if (!wdata[VRA_BIT]) begin
            dac_q <= RATE_48K;
            adc_q <= RATE_48K;
          end
          if (!wdata[VRM_BIT]) mic_q <= RATE_48K;
        end
        K_DAC: if (ext_q[VRA_BIT]) dac_q <= wdata;
        K_ADC: if (ext_q[VRA_BIT]) adc_q <= wdata;
        K_MIC: if (ext_q[VRM_BIT]) mic_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_MASTER: spec_rdata = master_q;
      K_PCM:    spec_rdata = pcm_q;
      K_RGAIN:  spec_rdata = rgain_q;
      K_RSEL:   spec_rdata = rsel_q;
      K_PWR:    spec_rdata = pwr_q;
      K_EXTID:  spec_rdata = CONST_EXTID;
      K_EXTCTL: spec_rdata = ext_q;
      K_DAC:    spec_rdata = dac_q;
      K_ADC:    spec_rdata = adc_q;
      K_MIC:    spec_rdata = mic_q;
      K_VID1:   spec_rdata = CONST_VID1;
      K_VID2:   spec_rdata = CONST_VID2;
      default:  spec_rdata = '0;
    endcase
  end

  assign master_mute    = master_q[15];
  assign master_vol_l   = master_q[13:8];
  assign master_vol_r   = master_q[5:0];
  assign pcm_mute       = pcm_q[15];
  assign pcm_vol_l      = pcm_q[12:8];
  assign pcm_vol_r      = pcm_q[4:0];
  assign rec_mute       = rgain_q[15];
  assign rec_gain_l     = rgain_q[11:8];
  assign rec_gain_r     = rgain_q[3:0];
  assign rec_src_l      = rsel_q[10:8];
  assign rec_src_r      = rsel_q[2:0];
  assign front_dac_rate = dac_q;
  assign adc_rate       = adc_q;
  assign mic_rate       = mic_q;

  AST_VOL_FIELDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    ((master_q & ~MASK_MASTER) == '0) && ((pcm_q & ~MASK_PCM) == '0)
    && ((rgain_q & ~MASK_RGAIN) == '0)); // R2
  AST_PWR_STATUS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (pwr_q[3:0] == 4'hF) && !pwr_q[15]); // R4
  AST_RATE_HELD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == K_DAC && !ext_q[VRA_BIT]) |=> $stable(dac_q)); // R6
  AST_AUDIO_RATE_FORCED: assert property (@(posedge clk) disable iff (rst)
    !ext_q[VRA_BIT] |-> (dac_q == RATE_48K && adc_q == RATE_48K)); // R7
  AST_MIC_RATE_FORCED: assert property (@(posedge clk) disable iff (rst)
    !ext_q[VRM_BIT] |-> (mic_q == RATE_48K)); // R7
endmodule

// File: rtl/codec_mixer_regs.sv
module codec_mixer_regs
  import mixreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RSP_W  = 32,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  acc_size_e         req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_rdata,
  output logic              master_mute,
  output logic [5:0]        master_vol_l,
  output logic [5:0]        master_vol_r,
  output logic              pcm_mute,
  output logic [4:0]        pcm_vol_l,
  output logic [4:0]        pcm_vol_r,
  output logic              rec_mute,
  output logic [3:0]        rec_gain_l,
  output logic [3:0]        rec_gain_r,
  output logic [2:0]        rec_src_l,
  output logic [2:0]        rec_src_r,
  output logic [15:0]       front_dac_rate,
  output logic [15:0]       adc_rate,
  output logic [15:0]       mic_rate
);
  reg_kind_e        kind;
  logic [REG_W-1:0] plain_dflt, spec_rdata, mem_rdata;
  logic             mem_written;
  logic             access_ok, wr_ok, rd_req;

  assign access_ok = req_valid && (req_size == SZ_HALF) && !req_addr[0];
  assign wr_ok     = access_ok && req_write;
  assign rd_req    = req_valid && !req_write;

  mixreg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr       (req_addr),
    .kind       (kind),
    .plain_dflt (plain_dflt)
  );

  mixreg_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr      (wr_ok && kind == K_RESET),
    .we       (wr_ok && kind == K_PLAIN),
    .idx      (req_addr[ADDR_W-1:1]),
    .wdata    (req_wdata),
    .rdata    (mem_rdata),
    .rwritten (mem_written)
  );

  mixreg_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_ok),
    .kind           (kind),
    .wdata          (req_wdata),
    .spec_rdata     (spec_rdata),
    .master_mute    (master_mute),
    .master_vol_l   (master_vol_l),
    .master_vol_r   (master_vol_r),
    .pcm_mute       (pcm_mute),
    .pcm_vol_l      (pcm_vol_l),
    .pcm_vol_r      (pcm_vol_r),
    .rec_mute       (rec_mute),
    .rec_gain_l     (rec_gain_l),
    .rec_gain_r     (rec_gain_r),
    .rec_src_l      (rec_src_l),
    .rec_src_r      (rec_src_r),
    .front_dac_rate (front_dac_rate),
    .adc_rate       (adc_rate),
    .mic_rate       (mic_rate)
  );

  // Read stage: one registered cycle, matching the RAM read latency.
  logic             rsp_q, ok_q, plain_q;
  logic [REG_W-1:0] spec_q, dflt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q   <= 1'b0;
      ok_q    <= 1'b0;
      plain_q <= 1'b0;
      spec_q  <= '0;
      dflt_q  <= '0;
    end else begin
      rsp_q   <= rd_req;
      ok_q    <= access_ok;
      plain_q <= (kind == K_PLAIN);
      spec_q  <= spec_rdata;
      dflt_q  <= plain_dflt;
    end
  end

  logic [REG_W-1:0] sel_val;
  assign sel_val = plain_q ? (mem_written ? mem_rdata : dflt_q) : spec_q;

  always_comb begin
    if (!rsp_q)     rsp_rdata = '0;
    else if (!ok_q) rsp_rdata = '1;
    else            rsp_rdata = {{(RSP_W-REG_W){1'b0}}, sel_val};
  end
  assign rsp_valid = rsp_q;

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write)); // R12
  AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_size != SZ_HALF)) |-> (rsp_rdata == '1)); // R9
  AST_ODD_ADDR_ONES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr[0])) |-> (rsp_rdata == '1)); // R10
endmodule

// File: tb/tb_codec_mixer_regs.sv
module tb_codec_mixer_regs;
  import mixreg_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  acc_size_e   req_size = SZ_HALF;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        master_mute, pcm_mute, rec_mute;
  logic [5:0]  master_vol_l, master_vol_r;
  logic [4:0]  pcm_vol_l, pcm_vol_r;
  logic [3:0]  rec_gain_l, rec_gain_r;
  logic [2:0]  rec_src_l, rec_src_r;
  logic [15:0] front_dac_rate, adc_rate, mic_rate;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  codec_mixer_regs dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .master_mute(master_mute), .master_vol_l(master_vol_l), .master_vol_r(master_vol_r),
    .pcm_mute(pcm_mute), .pcm_vol_l(pcm_vol_l), .pcm_vol_r(pcm_vol_r),
    .rec_mute(rec_mute), .rec_gain_l(rec_gain_l), .rec_gain_r(rec_gain_r),
    .rec_src_l(rec_src_l), .rec_src_r(rec_src_r),
    .front_dac_rate(front_dac_rate), .adc_rate(adc_rate), .mic_rate(mic_rate)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d,
                        input acc_size_e sz = SZ_HALF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input acc_size_e sz,
                        output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp,
                        input acc_size_e sz = SZ_HALF);
    logic [31:0] d;
    logic v;
    bus_rd(a, sz, d, v);
    chk({tag, " rsp_valid"}, {31'd0, v}, 32'd1);
    chk(tag, d, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk_default_state(input string tag);
    rd_chk({tag, " master"}, 8'h02, 32'h8000);
    rd_chk({tag, " pcm"}, 8'h18, 32'h8808);
    rd_chk({tag, " rgain"}, 8'h1C, 32'h8808);
    rd_chk({tag, " rsel"}, 8'h1A, 32'h0000);
    rd_chk({tag, " pwr"}, 8'h26, 32'h000F);
    rd_chk({tag, " extid"}, 8'h28, 32'h0809);
    rd_chk({tag, " extctl"}, 8'h2A, 32'h0009);
    rd_chk({tag, " vid1"}, 8'h7C, 32'h8384);
    rd_chk({tag, " vid2"}, 8'h7E, 32'h7600);
    rd_chk({tag, " dac"}, 8'h2C, 32'hBB80);
    rd_chk({tag, " surround"}, 8'h2E, 32'hBB80);
    rd_chk({tag, " lfe"}, 8'h30, 32'hBB80);
    rd_chk({tag, " adc"}, 8'h32, 32'hBB80);
    rd_chk({tag, " mic"}, 8'h34, 32'hBB80);
    chk({tag, " out mvol"}, {19'd0, master_mute, master_vol_l, master_vol_r}, {19'd0, 1'b1, 6'd0, 6'd0});
    chk({tag, " out pcm"}, {21'd0, pcm_mute, pcm_vol_l, pcm_vol_r}, {21'd0, 1'b1, 5'd8, 5'd8});
    chk({tag, " out rgain"}, {23'd0, rec_mute, rec_gain_l, rec_gain_r}, {23'd0, 1'b1, 4'd8, 4'd8});
    chk({tag, " out rsrc"}, {26'd0, rec_src_l, rec_src_r}, 32'd0);
    chk({tag, " out rates"}, {front_dac_rate, adc_rate}, {16'hBB80, 16'hBB80});
    chk({tag, " out mic"}, {16'd0, mic_rate}, {16'd0, 16'hBB80});
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_default_state("R1 reset");
  endtask

  task automatic t_volume_masks();
    bus_wr(8'h02, 16'hFFFF);
    rd_chk("R2 master mask", 8'h02, 32'hBF3F);
    chk("R2 master out", {19'd0, master_mute, master_vol_l, master_vol_r}, {19'd0, 1'b1, 6'h3F, 6'h3F});
    bus_wr(8'h02, 16'h0102);
    chk("R2 master pattern", {19'd0, master_mute, master_vol_l, master_vol_r}, {19'd0, 1'b0, 6'd1, 6'd2});
    bus_wr(8'h18, 16'hFFFF);
    rd_chk("R2 pcm mask", 8'h18, 32'h9F1F);
    chk("R2 pcm out", {21'd0, pcm_mute, pcm_vol_l, pcm_vol_r}, {21'd0, 1'b1, 5'h1F, 5'h1F});
    bus_wr(8'h1C, 16'hFFFF);
    rd_chk("R2 rgain mask", 8'h1C, 32'h8F0F);
    bus_wr(8'h1C, 16'h0A05);
    chk("R2 rgain out", {23'd0, rec_mute, rec_gain_l, rec_gain_r}, {23'd0, 1'b0, 4'hA, 4'h5});
  endtask

  task automatic t_record_select();
    bus_wr(8'h1A, 16'hFFFF);
    rd_chk("R3 rsel mask", 8'h1A, 32'h0707);
    bus_wr(8'h1A, 16'hF3F5);
    chk("R3 rsel out", {26'd0, rec_src_l, rec_src_r}, {26'd0, 3'd3, 3'd5});
  endtask

  task automatic t_powerdown();
    bus_wr(8'h26, 16'hFFF0);
    rd_chk("R4 pwr all ones", 8'h26, 32'h7FFF);
    bus_wr(8'h26, 16'h0000);
    rd_chk("R4 pwr zero", 8'h26, 32'h000F);
  endtask

  task automatic t_read_only();
    bus_wr(8'h7C, 16'h1234);
    bus_wr(8'h7E, 16'h1234);
    bus_wr(8'h28, 16'h1234);
    bus_wr(8'h10, 16'h1234);
    bus_wr(8'h22, 16'h1234);
    bus_wr(8'h1E, 16'h1234);
    rd_chk("R5 vid1", 8'h7C, 32'h8384);
    rd_chk("R5 vid2", 8'h7E, 32'h7600);
    rd_chk("R5 extid", 8'h28, 32'h0809);
    rd_chk("R5 line", 8'h10, 32'h0000);
    rd_chk("R5 3d", 8'h22, 32'h0000);
    rd_chk("R5 micgain", 8'h1E, 32'h0000);
  endtask

  task automatic t_rate_gating();
    bus_wr(8'h2C, 16'hAC44);
    bus_wr(8'h32, 16'h5622);
    bus_wr(8'h34, 16'h3E80);
    rd_chk("R6 dac open", 8'h2C, 32'hAC44);
    chk("R6 rate outs", {front_dac_rate, adc_rate}, {16'hAC44, 16'h5622});
    chk("R6 mic out", {16'd0, mic_rate}, {16'd0, 16'h3E80});
  endtask

  task automatic t_ext_force();
    bus_wr(8'h2A, 16'h0008);
    chk("R7 audio forced", {front_dac_rate, adc_rate}, {16'hBB80, 16'hBB80});
    chk("R7 mic kept", {16'd0, mic_rate}, {16'd0, 16'h3E80});
    bus_wr(8'h2C, 16'h1111);
    bus_wr(8'h32, 16'h2222);
    rd_chk("R6 dac locked", 8'h2C, 32'hBB80);
    rd_chk("R6 adc locked", 8'h32, 32'hBB80);
    bus_wr(8'h34, 16'h4444);
    rd_chk("R6 mic still open", 8'h34, 32'h4444);
    bus_wr(8'h2A, 16'h0000);
    rd_chk("R7 ext stored", 8'h2A, 32'h0000);
    chk("R7 mic forced", {16'd0, mic_rate}, {16'd0, 16'hBB80});
    bus_wr(8'h34, 16'h1234);
    rd_chk("R6 mic locked", 8'h34, 32'hBB80);
    bus_wr(8'h2A, 16'h0009);
    bus_wr(8'h2C, 16'h7D00);
    rd_chk("R6 dac reopened", 8'h2C, 32'h7D00);
  endtask

  task automatic t_plain();
    rd_chk("R8 unwritten", 8'h40, 32'h0000);
    bus_wr(8'h40, 16'hA5A5);
    bus_wr(8'hFE, 16'h5A5A);
    bus_wr(8'h2E, 16'h1234);
    rd_chk("R8 plain 40", 8'h40, 32'hA5A5);
    rd_chk("R8 plain FE", 8'hFE, 32'h5A5A);
    rd_chk("R8 plain 2E", 8'h2E, 32'h1234);
  endtask

  task automatic t_access_size();
    rd_chk("R9 byte read", 8'h02, 32'hFFFFFFFF, SZ_BYTE);
    rd_chk("R9 word read", 8'h2C, 32'hFFFFFFFF, SZ_WORD);
    rd_chk("R9 rsvd read", 8'h40, 32'hFFFFFFFF, SZ_RSVD);
    bus_wr(8'h02, 16'h0000, SZ_BYTE);
    bus_wr(8'h40, 16'h0000, SZ_WORD);
    bus_wr(8'h00, 16'h0000, SZ_BYTE);
    rd_chk("R9 byte write ignored", 8'h02, 32'h0102);
    rd_chk("R9 word write ignored", 8'h40, 32'hA5A5);
  endtask

  task automatic t_odd_addr();
    rd_chk("R10 odd read", 8'h03, 32'hFFFFFFFF);
    bus_wr(8'h41, 16'h7777);
    bus_wr(8'h03, 16'h0000);
    rd_chk("R10 odd write 40", 8'h40, 32'hA5A5);
    rd_chk("R10 odd write 42", 8'h42, 32'h0000);
    rd_chk("R10 odd write master", 8'h02, 32'h0102);
  endtask

  task automatic t_reset_reg();
    bus_wr(8'h2A, 16'h0000);
    bus_wr(8'h00, 16'hDEAD);
    rd_chk("R11 reset reads zero", 8'h00, 32'h0000);
    rd_chk("R11 plain cleared", 8'h40, 32'h0000);
    rd_chk("R11 plain FE cleared", 8'hFE, 32'h0000);
    chk_default_state("R11 reg reset");
  endtask

  task automatic t_rsp_timing();
    logic [31:0] d;
    logic v;
    bus_wr(8'h44, 16'hBEEF);
    chk("R12 no rsp after write", {31'd0, rsp_valid}, 32'd0);
    bus_rd(8'h44, SZ_HALF, d, v);
    chk("R12 rsp after read", {31'd0, v}, 32'd1);
    chk("R12 upper zero", d, 32'h0000BEEF);
    @(negedge clk);
    chk("R12 rsp single cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_pin_reset();
    bus_wr(8'h02, 16'h0303);
    bus_wr(8'h2A, 16'h0000);
    do_reset();
    chk_default_state("R1 pin reset");
    rd_chk("R1 pin reset plain", 8'h44, 32'h0000);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    t_reset_state();
    t_volume_masks();
    t_record_select();
    t_powerdown();
    t_read_only();
    t_rate_gating();
    t_ext_force();
    t_plain();
    t_access_size();
    t_odd_addr();
    t_reset_reg();
    t_rsp_timing();
    t_pin_reset();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R12 actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule